// File: doc/BRIEF.md
# Instrument Event Status Reporting Unit

This block keeps a record of instrument events and condenses them into one service request line. Six event pulse inputs, an operation-complete strobe gated by a busy signal, and the power-up condition each set a sticky bit in a 16-bit event register. The bits stay set until a controller reads the register, and that read also clears it. An event mask picks which latched events drive a summary bit at position 5 of an 8-bit status byte. A second mask picks which status-byte bits raise the service request.

The other status-byte positions come from the `aux_stat_i` input, which carries summaries produced by logic outside this block. Position 6 of the status byte shows the service request itself. A small register port lets a controller read the event register and the status byte, and read or write both masks. The controller drives `req_i` for one cycle and the read data appears on `rdata_o` on the following cycle. A level input sets the power-on-clear policy for reset: reset either clears both masks or keeps them.

Top module: `evstat_unit`

## Requirements
- R1: Event register bit 0 is operation complete, bit 7 is power-on, and bits 1 to 6 are set by `ev_pulse_i[0]` to `ev_pulse_i[5]` in that order.
- R2: Event register bits 15 to 8 always read as zero. Only write bits 7 to 0 are stored in a mask, so mask bits 15 to 8 read as zero.
- R3: A set event bit stays set after its pulse ends, until the event register is read.
- R4: A read of register 0 (event register) returns its value on `rdata_o` one cycle later and clears it in the same cycle. An event that arrives in the read cycle is set afterwards.
- R5: Status byte bit 5 is the OR of the event register ANDed with the event mask. It changes in the cycle after an event or a mask write.
- R6: The service request mask never stores bit 6, so that bit reads as 0. `srq_o` is the OR of the status byte, with bit 6 taken as 0, ANDed with the service request mask. Status byte bit 6 equals `srq_o`.
- R7: An operation-complete strobe taken while `busy_i` is low sets bit 0 one cycle later. A strobe taken while `busy_i` is high is held pending, and it sets bit 0 in the cycle after the first cycle in which `busy_i` is low.
- R8: A synchronous reset loads the event register with 0x0080 and clears the pending operation-complete strobe. It clears both masks when `pwr_clr_i` is high and leaves them unchanged when `pwr_clr_i` is low.
- R9: Register map: address 0 is the event register (read clears it), address 1 is the status byte (read only), address 2 is the event mask (read/write), and address 3 is the service request mask (read/write). Writes to addresses 0 and 1 are ignored. `rdata_o` holds the result of the last read until the next read.
- R10: Status byte bits 7 and 4 to 0 follow `aux_stat_i` combinationally. Bits 5 and 6 of `aux_stat_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset (power cycle) |
| pwr_clr_i | input | 1 | Clear both masks on reset when high |
| ev_pulse_i | input | 6 | Event pulses for event bits 1 to 6 |
| opc_cmd_i | input | 1 | Operation-complete command strobe |
| busy_i | input | 1 | Operations still pending |
| aux_stat_i | input | 8 | External status-byte bits (5 and 6 ignored) |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| stb_o | output | 8 | Status byte |
| srq_o | output | 1 | Service request |

## Verification
The hardest cases involve two events in the same cycle: a read of the event register in the same cycle as a new event pulse, and an operation-complete strobe that arrives while the unit is busy and must be remembered until busy drops. The stimulus produces both on purpose. It drives a pulse in the exact read cycle, then reads again to confirm that only the new bit survived. It holds busy high across several idle cycles and register reads before releasing it. A randomized phase then mixes pulses, strobes, masks, reads and resets, and a behavioural model checks the outputs after every clock.

// File: rtl/evsr_pkg.sv
`timescale 1ns/1ps
package evsr_pkg;
    localparam int DATA_W  = 16;
    localparam int EVT_W   = 8;
    localparam int ADDR_W  = 2;
    localparam int PULSE_W = EVT_W - 2;
    localparam int SUM_POS = 5;
    localparam int RQS_POS = 6;
    localparam logic [EVT_W-1:0] EVT_RESET = EVT_W'(1) << (EVT_W - 1);

    typedef enum logic [ADDR_W-1:0] {
        REG_EVENT  = 2'd0,
        REG_STATUS = 2'd1,
        REG_EV_EN  = 2'd2,
        REG_SRQ_EN = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [EVT_W-1:0] ev_en;
        logic [EVT_W-1:0] srq_en;
    } mask_t;

    function automatic logic [EVT_W-1:0] merge_base(input logic [EVT_W-1:0] aux,
                                                    input logic summary);
        logic [EVT_W-1:0] b;
        b          = aux;
        b[SUM_POS] = summary;
        b[RQS_POS] = 1'b0;
        return b;
    endfunction
endpackage

// File: rtl/evsr_event_reg.sv
`timescale 1ns/1ps
module evsr_event_reg
    import evsr_pkg::*;
#(
    parameter int W  = EVT_W,
    parameter int PW = PULSE_W
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [PW-1:0] pulse_i,
    input  logic         opc_cmd_i,
    input  logic         busy_i,
    input  logic         clr_i,
    output logic [W-1:0] ev_o
);
    logic [W-1:0] ev_q;
    logic [W-1:0] set_v;
    logic         pend_q;
    logic         opc_go;
    logic         opc_fire;

    assign opc_go   = opc_cmd_i | pend_q;
    assign opc_fire = opc_go & ~busy_i;
    assign set_v    = {1'b0, pulse_i, opc_fire};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ev_q   <= EVT_RESET;
            pend_q <= 1'b0;
        end else begin
            ev_q   <= (clr_i ? '0 : ev_q) | set_v;
            pend_q <= opc_go & busy_i;
        end
    end

    assign ev_o = ev_q;

    assert_sticky_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_i |=> (($past(ev_q) & ~ev_q) == '0));
    assert_pulse_sets_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (pulse_i != '0) |=> ((ev_q[W-2:1] & $past(pulse_i)) == $past(pulse_i)));
    assert_opc_sets_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (opc_cmd_i && !busy_i) |=> ev_q[0]);
    assert_poweron_R8: assert property (@(posedge clk_i)
        rst_i |=> (ev_q == EVT_RESET));
    assert_clear_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_i && pulse_i == '0 && !opc_cmd_i && !pend_q) |=> (ev_q == '0));
endmodule

// File: rtl/evsr_masks.sv
`timescale 1ns/1ps
module evsr_masks
    import evsr_pkg::*;
#(
    parameter int W     = EVT_W,
    parameter int SKIP  = RQS_POS
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         pwr_clr_i,
    input  logic         wr_een_i,
    input  logic         wr_sre_i,
    input  logic [W-1:0] wdata_i,
    output mask_t        mask_o
);
    logic [W-1:0] een_q;
    logic [W-1:0] sre_bits;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            if (pwr_clr_i) een_q <= '0;
        end else if (wr_een_i) begin
            een_q <= wdata_i;
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_sre
        if (i == SKIP) begin : g_hole
            assign sre_bits[i] = 1'b0;
        end else begin : g_bit
            logic b_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    if (pwr_clr_i) b_q <= 1'b0;
                end else if (wr_sre_i) begin
                    b_q <= wdata_i[i];
                end
            end
            assign sre_bits[i] = b_q;
        end
    end

    assign mask_o.ev_en  = een_q;
    assign mask_o.srq_en = sre_bits;

    assert_pwr_clear_R8: assert property (@(posedge clk_i)
        (rst_i && pwr_clr_i) |=> (een_q == '0 && sre_bits == '0));
    assert_pwr_keep_R8: assert property (@(posedge clk_i)
        (rst_i && !pwr_clr_i) |=> $stable(een_q));
    assert_een_write_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_een_i |=> (een_q == $past(wdata_i)));
endmodule

// File: rtl/evsr_summary.sv
`timescale 1ns/1ps
module evsr_summary
    import evsr_pkg::*;
#(
    parameter int W = EVT_W
) (
    input  logic [W-1:0] ev_i,
    input  mask_t        mask_i,
    input  logic [W-1:0] aux_i,
    output logic [W-1:0] stb_o,
    output logic         srq_o
);
    logic         summary;
    logic [W-1:0] base;

    always_comb begin
        summary = |(ev_i & mask_i.ev_en);
        base    = merge_base(aux_i, summary);
        srq_o   = |(base & mask_i.srq_en);
        stb_o   = base;
        stb_o[RQS_POS] = srq_o;
    end
endmodule

// File: rtl/evstat_unit.sv
`timescale 1ns/1ps
module evstat_unit
    import evsr_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                pwr_clr_i,
    input  logic [PULSE_W-1:0]  ev_pulse_i,
    input  logic                opc_cmd_i,
    input  logic                busy_i,
    input  logic [EVT_W-1:0]    aux_stat_i,
    input  logic                req_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [EVT_W-1:0]    stb_o,
    output logic                srq_o
);
    reg_sel_e          sel;
    logic              rd_en;
    logic              wr_en;
    logic              clr_ev;
    logic [EVT_W-1:0]  ev;
    mask_t             mask;
    logic [EVT_W-1:0]  rd_mux;
    logic [DATA_W-1:0] rdata_q;
    wire               unused_wdata_hi = ^wdata_i[DATA_W-1:EVT_W];

    assign sel    = reg_sel_e'(addr_i);
    assign rd_en  = req_i & ~we_i;
    assign wr_en  = req_i & we_i;
    assign clr_ev = rd_en && (sel == REG_EVENT);

    evsr_event_reg u_event (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pulse_i   (ev_pulse_i),
        .opc_cmd_i (opc_cmd_i),
        .busy_i    (busy_i),
        .clr_i     (clr_ev),
        .ev_o      (ev)
    );

    evsr_masks u_masks (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pwr_clr_i (pwr_clr_i),
        .wr_een_i  (wr_en && sel == REG_EV_EN),
        .wr_sre_i  (wr_en && sel == REG_SRQ_EN),
        .wdata_i   (wdata_i[EVT_W-1:0]),
        .mask_o    (mask)
    );

    evsr_summary u_sum (
        .ev_i   (ev),
        .mask_i (mask),
        .aux_i  (aux_stat_i),
        .stb_o  (stb_o),
        .srq_o  (srq_o)
    );

    always_comb begin
        unique case (sel)
            REG_EVENT:  rd_mux = ev;
            REG_STATUS: rd_mux = stb_o;
            REG_EV_EN:  rd_mux = mask.ev_en;
            default:    rd_mux = mask.srq_en;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rdata_q <= '0;
        else if (rd_en) rdata_q <= {{(DATA_W-EVT_W){1'b0}}, rd_mux};
    end

    assign rdata_o = rdata_q;

    assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_en |=> $stable(rdata_o));
    assert_srq_flag_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        srq_o |-> (stb_o[RQS_POS] && (mask.srq_en & stb_o) != '0));
    assert_upper_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        rd_en |=> (rdata_o[DATA_W-1:EVT_W] == '0));
endmodule

// File: tb/evstat_unit_tb_top.sv
`timescale 1ns/1ps
module evstat_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_clr = 1'b1;
    logic [5:0]  ev_pulse = '0;
    logic        opc_cmd = 1'b0;
    logic        busy = 1'b0;
    logic [7:0]  aux = '0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  stb;
    logic        srq;

    int n_chk = 0;
    int n_bad = 0;
    bit mdl_on = 0;
    bit done = 0;

    always #4 clk = ~clk;

    evstat_unit dut_i (
        .clk_i(clk), .rst_i(rst), .pwr_clr_i(pwr_clr), .ev_pulse_i(ev_pulse),
        .opc_cmd_i(opc_cmd), .busy_i(busy), .aux_stat_i(aux), .req_i(req),
        .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .stb_o(stb), .srq_o(srq)
    );

    // behavioural reference model
    int m_ev, m_een, m_sre, m_rd;
    bit m_pend;

    function automatic int ref_base();
        int s = 0;
        for (int i = 0; i < 8; i++)
            if (((m_ev >> i) & 1) && ((m_een >> i) & 1)) s = 1;
        return (aux & 'h9F) | (s << 5);
    endfunction
    function automatic int ref_srq();
        return ((ref_base() & m_sre) != 0) ? 1 : 0;
    endfunction
    function automatic int ref_stb();
        return ref_base() | (ref_srq() << 6);
    endfunction

    initial begin m_ev = 0; m_een = 0; m_sre = 0; m_rd = 0; m_pend = 0; end

    always @(posedge clk) begin
        if (rst) begin
            m_ev = 'h80; m_pend = 0; m_rd = 0;
            if (pwr_clr) begin m_een = 0; m_sre = 0; end
        end else begin
            bit go, fire;
            int setv;
            go = opc_cmd || m_pend;
            fire = go && !busy;
            m_pend = go && busy;
            setv = (int'(ev_pulse) << 1) | int'(fire);
            if (req && !we) begin
                case (addr)
                    2'd0: m_rd = m_ev;
                    2'd1: m_rd = ref_stb();
                    2'd2: m_rd = m_een;
                    default: m_rd = m_sre;
                endcase
            end
            m_ev = ((req && !we && addr == 2'd0) ? 0 : m_ev) | setv;
            if (req && we && addr == 2'd2) m_een = wdata & 'hFF;
            if (req && we && addr == 2'd3) m_sre = wdata & 'hBF;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (mdl_on && !rst) begin
            chk("R5/R10 model stb", int'(stb), ref_stb());
            chk("R6 model srq", int'(srq), ref_srq());
            chk("R4/R9 model rdata", int'(rdata), m_rd);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); req = 0; we = 0; #1;
    endtask
    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk); req = 1; we = 0; addr = a;
        @(negedge clk); req = 0; #1; v = int'(rdata);
    endtask
    task automatic pulse(input logic [5:0] p);
        @(negedge clk); ev_pulse = p;
        @(negedge clk); ev_pulse = '0; #1;
    endtask
    task automatic do_reset(input bit pc);
        @(negedge clk); rst = 1; pwr_clr = pc;
        repeat (2) @(negedge clk);
        rst = 0; #1;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 0; #1;
        mdl_on = 1;
        chk("R8 reset stb", int'(stb), 0);
        chk("R8 reset srq", int'(srq), 0);
        rd(2'd0, v); chk("R8 power-on bit", v, 'h0080);
        rd(2'd0, v); chk("R4 cleared by read", v, 0);
        // masks
        wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R2 mask upper bits", v, 'h00FF);
        wr(2'd2, 16'd60);
        wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R6 sre bit6 not stored", v, 'h00BF);
        wr(2'd3, 16'd32);
        // error event raises summary and request
        pulse(6'b000100);
        chk("R5 summary set", int'(stb), 'h60);
        chk("R6 srq raised", int'(srq), 1);
        repeat (4) @(negedge clk); #1;
        chk("R3 sticky", int'(stb), 'h60);
        rd(2'd1, v); chk("R9 status byte read", v, 'h0060);
        // read clear with concurrent event
        @(negedge clk); req = 1; we = 0; addr = 2'd0; ev_pulse = 6'b000001;
        @(negedge clk); req = 0; ev_pulse = '0; #1;
        chk("R4 read value", int'(rdata), 'h0008);
        chk("R5 summary dropped", int'(stb), 0);
        rd(2'd0, v); chk("R4 concurrent event kept (R1 bit1)", v, 'h0002);
        // writes to read-only addresses
        wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R9 write to event ignored", v, 0);
        wr(2'd1, 16'hFFFF); rd(2'd1, v); chk("R9 write to status ignored", v, 0);
        // operation complete while busy
        @(negedge clk); busy = 1; opc_cmd = 1;
        @(negedge clk); opc_cmd = 0;
        repeat (3) @(negedge clk);
        rd(2'd0, v); chk("R7 held while busy", v, 0);
        @(negedge clk); busy = 0;
        @(negedge clk); #1;
        rd(2'd0, v); chk("R7 pending fires", v, 'h0001);
        @(negedge clk); opc_cmd = 1;
        @(negedge clk); opc_cmd = 0; #1;
        rd(2'd0, v); chk("R7 immediate", v, 'h0001);
        // bit map of pulse inputs
        pulse(6'h3F); rd(2'd0, v); chk("R1 all pulses", v, 'h007E);
        pulse(6'h20); rd(2'd0, v); chk("R1 user request bit6", v, 'h0040);
        // aux status pass-through
        @(negedge clk); aux = 8'hFF;
        wr(2'd3, 16'h0001);
        chk("R10 aux merged", int'(stb), 'hDF);
        chk("R6 srq from aux", int'(srq), 1);
        @(negedge clk); aux = 8'h80; #1;
        chk("R10 aux bit7", int'(stb), 'h80);
        chk("R6 srq off", int'(srq), 0);
        @(negedge clk); aux = 8'h40;
        wr(2'd3, 16'h0040);
        chk("R6 bit6 ignored srq", int'(srq), 0);
        chk("R10 aux bit6 ignored", int'(stb), 0);
        aux = 8'h00;
        // reset policy
        wr(2'd2, 16'h0011); wr(2'd3, 16'h0022);
        do_reset(0);
        rd(2'd2, v); chk("R8 een kept", v, 'h0011);
        rd(2'd3, v); chk("R8 sre kept", v, 'h0022);
        do_reset(1);
        rd(2'd2, v); chk("R8 een cleared", v, 0);
        rd(2'd3, v); chk("R8 sre cleared", v, 0);
        // randomized phase checked against the model every cycle
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            ev_pulse = ($urandom % 4 == 0) ? 6'($urandom) : '0;
            opc_cmd  = ($urandom % 6 == 0);
            busy     = ($urandom % 3 == 0);
            aux      = 8'($urandom);
            req      = ($urandom % 2 == 0);
            we       = ($urandom % 3 == 0);
            addr     = 2'($urandom);
            wdata    = 16'($urandom);
            rst      = ($urandom % 150 == 0);
            pwr_clr  = ($urandom % 2 == 0);
        end
        @(negedge clk);
        rst = 0; req = 0; we = 0; ev_pulse = '0; opc_cmd = 0;
        repeat (3) @(negedge clk);
        #2;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule